// File: doc/BRIEF.md
# Multicast Branch Request Sequencer

At a router where a multicast tree splits, one flit at the head of an input virtual channel must leave through several output ports. This block sits beside that input channel. When a head flit is offered, the block takes in two values from the tree lookup: a mask of the output ports the flit must reach and a small count field. It then asks the allocators for those ports one at a time, with one request per cycle, and counts the grants that come back. The flit stays in the input buffer for this whole time.

When the grant count reaches the stored count, the block does three things. It pulses a completion strobe, tells the buffer to free the slot in that same cycle, and sends exactly one credit upstream on the next cycle. A flit that does not branch has a count of one, so it goes through a single request and grant like any unicast flit. The port mask and the count come from separate fields, and they can disagree. When they do, the block raises an error pulse and still ends the flit in a fixed way, so it never hangs.

The arbiters, the crossbar and the buffer storage are outside this block. The request, the port index and the grant form a plain valid/grant pair with the switch allocator.

Top module: `mcast_branch_seq`

## Requirements
- R1: When idle and `head_valid` is high at a clock edge, the block takes the head flit and `busy` is high from the next cycle. While `busy` is high, the head inputs are ignored.
- R2: The marked ports are requested in ascending index order, lowest first, with at most one request per cycle. `req_port` is the binary index of the port, where bit i of `head_mask` is port i.
- R3: A request that gets no grant is repeated in the next cycle with the same `req_port`.
- R4: `done` and `buf_free` are high together, only in the cycle where the grant that completes the flit is given. `credit_out` is a one-cycle pulse in the cycle after `done`.
- R5: With `head_count` = 1 and a single marked port, the flit makes exactly one request and completes on its first grant.
- R6: A new head flit can be taken in the cycle right after `done`. Its first request appears one cycle later.
- R7: `count_err` pulses in the cycle after a flit is taken if the mask is empty or the number of set mask bits differs from `head_count`.
- R8: With a mismatch, the flit completes at whichever comes first: the grant whose number equals `head_count`, or the grant for the last marked port. No further ports are requested after that.
- R9: A flit with an empty mask raises `done` and `buf_free` in the first cycle after it is taken, without making any request.
- R10: After synchronous reset, every output is low.
- R11: `req_grant` has no effect while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| head_valid | input | 1 | A flit waits at the head of the input channel |
| head_mask | input | NUM_PORTS | Output ports the flit must reach, bit i = port i |
| head_count | input | CNT_W | Number of grants required for the flit |
| req_grant | input | 1 | Allocator grants the current request |
| req_valid | output | 1 | A request is being presented |
| req_port | output | PORT_W | Index of the requested output port |
| done | output | 1 | Final grant of the flit is given in this cycle |
| buf_free | output | 1 | Release the input buffer slot at this edge |
| credit_out | output | 1 | One credit returned upstream |
| count_err | output | 1 | Mask and count field disagree for the flit just taken |
| busy | output | 1 | A flit is being sequenced |

## Verification
Two things can land in the same cycle, and these are the main concern. First, the last grant of one flit (`done`) can coincide with the upstream side already offering the next head flit. Second, a grant can arrive while a mismatch makes the count-limit stop and the end-of-mask stop compete. The bench offers flits back to back with no idle gap, and it holds mismatched count fields above and below the mask population. It also holds grants low on chosen cycles so that repeats shift the final grant. A behavioural queue model predicts every output in every cycle, so the completion cycle, the credit that follows it, and the cycle when the next flit is taken are all judged cycle by cycle.

// File: rtl/mbrs_pkg.sv
package mbrs_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mbrs_lowpick.sv
module mbrs_lowpick #(
  parameter int N = 5,
  parameter int W = 3
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx,
  output logic [N-1:0] rest
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end

  assign any  = |vec;
  assign rest = vec & ~(N'(1) << idx);
endmodule

// File: rtl/mbrs_popcnt.sv
module mbrs_popcnt #(
  parameter int N  = 5,
  parameter int OW = 3
) (
  input  logic [N-1:0]  vec,
  output logic [OW-1:0] cnt
);
  logic [OW-1:0] part [N+1];

  assign part[0] = '0;
  for (genvar g = 0; g < N; g++) begin : g_add
    assign part[g+1] = part[g] + OW'(vec[g]);
  end

  assign cnt = part[N];
endmodule

// File: rtl/mbrs_tracker.sv
module mbrs_tracker #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_need,
  input  logic          step,
  output logic          at_last
);
  logic [CW-1:0] need_q;
  logic [CW-1:0] got_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      need_q <= '0;
      got_q  <= '0;
    end else if (load) begin
      need_q <= load_need;
      got_q  <= '0;
    end else if (step) begin
      got_q  <= got_q + 1'b1;
    end
  end

  assign at_last = ({1'b0, got_q} + 1'b1) == {1'b0, need_q};
endmodule

// File: rtl/mcast_branch_seq.sv
module mcast_branch_seq #(
  parameter int NUM_PORTS = 5,
  parameter int CNT_W     = 3,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 head_valid,
  input  logic [NUM_PORTS-1:0] head_mask,
  input  logic [CNT_W-1:0]     head_count,
  input  logic                 req_grant,
  output logic                 req_valid,
  output logic [PORT_W-1:0]    req_port,
  output logic                 done,
  output logic                 buf_free,
  output logic                 credit_out,
  output logic                 count_err,
  output logic                 busy
);
  import mbrs_pkg::*;

  localparam int PC_W = (CNT_W > $clog2(NUM_PORTS + 1)) ? CNT_W : $clog2(NUM_PORTS + 1);

  seq_state_e           state_q;
  logic [NUM_PORTS-1:0] pend_q;
  logic                 credit_q;
  logic                 err_q;

  logic                 pend_any;
  logic [PORT_W-1:0]    pend_idx;
  logic [NUM_PORTS-1:0] pend_rest;
  logic [PC_W-1:0]      mask_pop;
  logic                 at_last;
  logic                 accept;
  logic                 take;
  logic                 last_grant;
  logic                 active;

  mbrs_lowpick #(.N(NUM_PORTS), .W(PORT_W)) u_pick (
    .vec  (pend_q),
    .any  (pend_any),
    .idx  (pend_idx),
    .rest (pend_rest)
  );

  mbrs_popcnt #(.N(NUM_PORTS), .OW(PC_W)) u_pop (
    .vec (head_mask),
    .cnt (mask_pop)
  );

  assign active     = (state_q == SEQ_ISSUE);
  assign accept     = !active && head_valid;
  assign req_valid  = active && pend_any;
  assign take       = req_valid && req_grant;
  assign last_grant = take && (at_last || !(|pend_rest));

  mbrs_tracker #(.CW(CNT_W)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_need (head_count),
    .step      (take),
    .at_last   (at_last)
  );

  assign done       = active && (!pend_any || last_grant);
  assign buf_free   = done;
  assign req_port   = pend_idx;
  assign credit_out = credit_q;
  assign count_err  = err_q;
  assign busy       = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      pend_q   <= '0;
      credit_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      credit_q <= done;
      err_q    <= accept && ((head_mask == '0) || (mask_pop != PC_W'(head_count)));
      if (accept) begin
        state_q <= SEQ_ISSUE;
        pend_q  <= head_mask;
      end else if (active) begin
        if (done) begin
          state_q <= SEQ_IDLE;
          pend_q  <= '0;
        end else if (take) begin
          pend_q  <= pend_rest;
        end
      end
    end
  end

  // R2: after a non-final grant the next request is for a higher port
  p_ascending_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_grant && !done) |=> (req_valid && (req_port > $past(req_port))));

  // R3: an ungranted request repeats on the same port
  p_repeat_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_grant) |=> (req_valid && $stable(req_port)));

  // R4: completion is followed by exactly one credit
  p_credit_after_done_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> credit_out);

  p_credit_only_after_done_r4: assert property (@(posedge clk) disable iff (rst)
    credit_out |-> $past(done));

  // R1: no request and no completion while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!req_valid && !done));

  // R7: the error pulse only follows a taken flit
  p_err_busy_r7: assert property (@(posedge clk) disable iff (rst)
    count_err |-> busy);

  // R9: an empty pending set completes without a request
  p_empty_done_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !req_valid) |-> done);
endmodule

// File: tb/mcast_branch_seq_test.sv
`timescale 1ns/1ps
module mcast_branch_seq_test;
  localparam int NP = 5;
  localparam int CW = 3;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          head_valid = 1'b0;
  logic [NP-1:0] head_mask = '0;
  logic [CW-1:0] head_count = '0;
  logic          req_grant = 1'b0;
  logic          req_valid, done, buf_free, credit_out, count_err, busy;
  logic [PW-1:0] req_port;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mcast_branch_seq #(.NUM_PORTS(NP), .CNT_W(CW), .PORT_W(PW)) uut (
    .clk(clk), .rst(rst), .head_valid(head_valid), .head_mask(head_mask),
    .head_count(head_count), .req_grant(req_grant), .req_valid(req_valid),
    .req_port(req_port), .done(done), .buf_free(buf_free),
    .credit_out(credit_out), .count_err(count_err), .busy(busy)
  );

  // behavioural reference: a queue of remaining ports
  bit m_busy = 0;
  int m_q[$];
  int m_need = 0;
  int m_got = 0;
  bit m_credit = 0;
  bit m_err = 0;

  task automatic chk(string scn, string fld, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s cycle %0d actual=%0d expected=%0d", scn, fld, cyc, act, exp);
    end
  endtask

  function automatic bit e_req();
    return m_busy && (m_q.size() > 0);
  endfunction

  function automatic bit e_done();
    return m_busy && ((m_q.size() == 0) ||
      (req_grant && (((m_got + 1) == m_need) || (m_q.size() == 1))));
  endfunction

  task automatic compare(string scn);
    chk(scn, "R1 busy", busy, m_busy);
    chk(scn, "R2 req_valid", req_valid, e_req());
    if (e_req()) chk(scn, "R2/R3 req_port", req_port, m_q[0]);
    chk(scn, "R4 done", done, e_done());
    chk(scn, "R4 buf_free", buf_free, e_done());
    chk(scn, "R4 credit_out", credit_out, m_credit);
    chk(scn, "R7 count_err", count_err, m_err);
  endtask

  task automatic model_step(bit dn);
    bit acc;
    acc = !m_busy && head_valid;
    m_credit = dn;
    m_err = 0;
    if (acc) begin
      m_busy = 1;
      m_q.delete();
      for (int i = 0; i < NP; i++) if (head_mask[i]) m_q.push_back(i);
      m_need = head_count;
      m_got = 0;
      m_err = (head_mask == 0) || (m_q.size() != int'(head_count));
    end else if (m_busy) begin
      if (dn) begin
        m_busy = 0;
        m_q.delete();
      end else if (e_req() && req_grant) begin
        void'(m_q.pop_front());
        m_got++;
      end
    end
  endtask

  // one cycle: drive at negedge, compare, commit model after posedge
  task automatic tick(string scn, bit hv, logic [NP-1:0] msk, logic [CW-1:0] cnt,
                      bit gnt, output bit saw_done);
    bit dn;
    @(negedge clk);
    head_valid = hv;
    head_mask = msk;
    head_count = cnt;
    req_grant = gnt;
    #1;
    compare(scn);
    dn = e_done();
    saw_done = done;
    @(posedge clk);
    model_step(dn);
  endtask

  task automatic run_flit(string scn, logic [NP-1:0] msk, logic [CW-1:0] cnt,
                          logic [15:0] gpat, bit scramble);
    bit sd;
    for (int k = 0; k < 40; k++) begin
      if (scramble && k > 0)
        tick(scn, k[0], ~msk, cnt + CW'(k), gpat[k % 16], sd);
      else
        tick(scn, 1'b1, msk, cnt, gpat[k % 16], sd);
      if (sd) break;
    end
  endtask

  task automatic idle(string scn, int n, bit gnt);
    bit sd;
    for (int k = 0; k < n; k++) tick(scn, 1'b0, 5'b10101, 3'd2, gnt, sd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk) cyc++;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    chk("R10", "busy", busy, 0);
    chk("R10", "req_valid", req_valid, 0);
    chk("R10", "done", done, 0);
    chk("R10", "credit_out", credit_out, 0);
    chk("R10", "count_err", count_err, 0);
    @(posedge clk);

    idle("R11", 3, 1'b1);                                 // R11: stray grants while idle
    run_flit("R5", 5'b00100, 3'd1, 16'hFFFF, 0);          // R5: non-branching
    idle("R5", 1, 1'b0);
    run_flit("R2", 5'b10110, 3'd3, 16'hFFFF, 0);          // R2: ascending order
    idle("R2", 2, 1'b0);
    run_flit("R3", 5'b11001, 3'd3, 16'b0101_0010_0110_1000, 0); // R3: repeats
    run_flit("R6", 5'b00011, 3'd2, 16'hFFFF, 0);          // R6: back to back
    run_flit("R6", 5'b11000, 3'd2, 16'hFFFE, 0);
    run_flit("R8", 5'b01111, 3'd2, 16'hFFFF, 0);          // R8: count below mask
    run_flit("R8", 5'b00011, 3'd5, 16'b1011_0110_1101_1011, 0); // R8: count above mask
    run_flit("R9", 5'b00000, 3'd0, 16'hFFFF, 0);          // R9: empty mask
    run_flit("R1", 5'b10101, 3'd3, 16'b0110_1101_1010_0110, 1); // R1: inputs ignored while busy
    run_flit("R4", 5'b11111, 3'd5, 16'b1110_1011_0111_1010, 0); // R4: full fan-out
    idle("R11", 2, 1'b1);
    run_flit("R7", 5'b10001, 3'd7, 16'hFFFF, 0);          // R7: wide mismatch
    idle("R4", 3, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule